// File: doc/BRIEF.md
# Time-Shared Multiply-Accumulate FIR Filter

This block is a 21-tap finite impulse response filter with one multiplier and one adder. A 10-bit two's complement sample arrives with a one-cycle valid strobe. It goes into a 21-entry sample history. A small controller then steps through the taps at one tap per clock. In each step it multiplies the stored sample by a 6-bit signed coefficient and adds the product into a 16-bit accumulator. After the last tap the sum is latched. The upper 10 bits of the latched sum appear on the result port, and a result-valid pulse lasts a fixed number of cycles.

A bypass input routes the input strobe and the input data directly to the result port. A 6-bit debug port shows one of four internal views, chosen by a 2-bit select. The controller has three states, each with its own 5-bit code:

- **IDLE** (`5'b00001`): waiting for a sample. It moves to RUN when a sample is accepted.
- **RUN** (`5'b00010`): one tap per cycle. It moves to HOLD after the last tap.
- **HOLD** (`5'b00100`): result-valid is high. It moves back to IDLE when the hold count runs out.

Top module: `fir_serial_mac`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_valid` is 0, `res_data` is 0, and the debug port in select 3 reads `6'b000001`.
- R2: A sample is accepted when `smp_valid` is high, `bypass` is low and the controller is in IDLE.
  - The sample becomes history entry 0, and each older entry moves up by one. The history starts as all zeros.
  - Each pass computes y = sum over k = 0..20 of c[k]·x[k], where x[k] is history entry k. All arithmetic is two's complement and wraps at 16 bits.
  - `res_data` is bits 15:6 of y.
- R3: The coefficient for tap k is c[k] = 31 − 3·k, held as a 6-bit signed value, for k = 0..20.
- R4: The pass timing is as follows.
  - The clock edge that accepts a sample starts 21 RUN cycles, one for each tap k = 0..20 in order.
  - On the edge that ends the last RUN cycle, the result is latched and `res_valid` rises.
  - `res_valid` then stays high for exactly 5 cycles and falls.
- R5: `res_data` holds its latched value until the next pass latches a new one.
- R6: `smp_valid` is ignored during RUN and HOLD. It does not change the history or the running pass.
- R7: While `bypass` is high, `res_valid` equals `smp_valid` and `res_data` equals `smp_data` in the same cycle, with no register in between. No sample is accepted into the history.
- R8: Debug select 0 shows bits 5:0 of the latched 16-bit sum.
- R9: In RUN, debug select 1 shows the coefficient c[k] of the current tap k.
- R10: In RUN, debug select 2 shows bits 9:4 of history entry k for the current tap k.
- R11: Debug select 3 shows {overflow, state code}.
  - The state codes are IDLE `5'b00001`, RUN `5'b00010` and HOLD `5'b00100`.
  - Overflow is computed for the adder inputs a (the accumulator) and b (the product), with sum s. It is set when a[15] = b[15] = 1 and s[15] = 0, or when a[15] = b[15] = 0 and s[15] = 1.
  - Outside RUN, b is forced to zero, so overflow reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | New-sample strobe |
| smp_data | input | 10 | Input sample, two's complement |
| bypass | input | 1 | Route the input directly to the output |
| dbg_sel | input | 2 | Debug view select |
| res_valid | output | 1 | Result-valid pulse, or the bypassed strobe |
| res_data | output | 10 | Filtered result, or the bypassed data |
| dbg_data | output | 6 | Selected debug view |

## Verification
The bench builds the block with its defaults: 21 taps, 10-bit samples, 6-bit coefficients, a 16-bit accumulator and a 5-cycle hold.

With 21 taps, a run of full-scale samples of 511 reaches signed overflow early in each pass, because the first coefficients are large and positive. The per-cycle overflow bit in debug select 3 therefore changes within a single pass and can be compared against a model.

The most negative sample, −512, and strobes injected in both the RUN and HOLD states cover the extremes of the sample range and the ignore rule. The 5-cycle hold makes the length of the result-valid pulse easy to check for an off-by-one error.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic [4:0] {
        ST_IDLE = 5'b00001,
        ST_RUN  = 5'b00010,
        ST_HOLD = 5'b00100
    } fir_state_t;

    // Coefficient ramp: large positive first taps, negative tail.
    function automatic int tap_coef(input int k);
        return 31 - 3 * k;
    endfunction

endpackage

// File: rtl/fir_sample_fifo.sv
module fir_sample_fifo #(
    parameter int TAPS = 21,
    parameter int DW   = 10,
    parameter int TW   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic signed [DW-1:0] din,
    input  logic [TW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_data,
    output logic signed [DW-1:0] head
);
    logic signed [DW-1:0] stage [TAPS];

    always_ff @(posedge clk) begin
        if (rst)       stage[0] <= '0;
        else if (push) stage[0] <= din;
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)       stage[i] <= '0;
            else if (push) stage[i] <= stage[i-1];
        end
    end

    assign rd_data = stage[rd_idx];
    assign head    = stage[0];
endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int TAPS = 21,
    parameter int CW   = 6,
    parameter int TW   = 5
) (
    input  logic [TW-1:0]        idx,
    output logic signed [CW-1:0] coef
);
    logic signed [CW-1:0] table_q [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_rom
        assign table_q[k] = CW'(fir_pkg::tap_coef(k));
    end

    assign coef = table_q[idx];
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DW = 10,
    parameter int CW = 6,
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 last,
    input  logic signed [DW-1:0] smp,
    input  logic signed [CW-1:0] coef,
    output logic                 ovf,
    output logic [AW-1:0]        latch_q
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] opb;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] sum;

    assign prod = smp * coef;
    assign opb  = en ? AW'(prod) : '0;
    assign sum  = acc + opb;
    assign ovf  = (acc[AW-1] & opb[AW-1] & ~sum[AW-1]) |
                  (~acc[AW-1] & ~opb[AW-1] & sum[AW-1]);

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= sum;
    end

    always_ff @(posedge clk) begin
        if (rst)       latch_q <= '0;
        else if (last) latch_q <= sum;
    end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl #(
    parameter int TAPS      = 21,
    parameter int READY_LEN = 5,
    parameter int TW        = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic                 bypass,
    output fir_pkg::fir_state_t  st,
    output logic [TW-1:0]        tap,
    output logic                 accept,
    output logic                 mac_en,
    output logic                 last,
    output logic                 hold
);
    import fir_pkg::*;

    localparam int RW = $clog2(READY_LEN + 1);

    fir_state_t st_q, st_d;
    logic [RW-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (smp_valid && !bypass)     st_d = ST_RUN;
            ST_RUN:  if (tap == TW'(TAPS - 1))     st_d = ST_HOLD;
            ST_HOLD: if (rcnt == '0)               st_d = ST_IDLE;
            default:                               st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap  <= '0;
            rcnt <= '0;
        end else begin
            if (accept)                  tap  <= '0;
            else if (last)               tap  <= '0;
            else if (mac_en)             tap  <= tap + 1'b1;
            if (last)                    rcnt <= RW'(READY_LEN - 1);
            else if (hold && rcnt != '0) rcnt <= rcnt - 1'b1;
        end
    end

    always_comb begin
        accept = (st_q == ST_IDLE) && smp_valid && !bypass;
        mac_en = (st_q == ST_RUN);
        last   = (st_q == ST_RUN) && (tap == TW'(TAPS - 1));
        hold   = (st_q == ST_HOLD);
    end

    assign st = st_q;
endmodule

// File: rtl/fir_serial_mac.sv
module fir_serial_mac #(
    parameter int TAPS      = 21,
    parameter int DW        = 10,
    parameter int CW        = 6,
    parameter int AW        = 16,
    parameter int READY_LEN = 5,
    parameter int DBG_W     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          bypass,
    input  logic [1:0]    dbg_sel,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic [DBG_W-1:0] dbg_data
);
    localparam int TW = $clog2(TAPS);

    fir_pkg::fir_state_t st;
    logic [TW-1:0]        tap;
    logic                 accept, mac_en, last, hold, ovf;
    logic signed [DW-1:0] tap_smp, fifo_head;
    logic signed [CW-1:0] tap_coef;
    logic [AW-1:0]        acc_latch;

    fir_ctrl #(.TAPS(TAPS), .READY_LEN(READY_LEN), .TW(TW)) u_ctrl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .bypass(bypass),
        .st(st), .tap(tap), .accept(accept), .mac_en(mac_en),
        .last(last), .hold(hold)
    );

    fir_sample_fifo #(.TAPS(TAPS), .DW(DW), .TW(TW)) u_fifo (
        .clk(clk), .rst(rst), .push(accept), .din(smp_data),
        .rd_idx(tap), .rd_data(tap_smp), .head(fifo_head)
    );

    fir_coef_rom #(.TAPS(TAPS), .CW(CW), .TW(TW)) u_rom (
        .idx(tap), .coef(tap_coef)
    );

    fir_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
        .clk(clk), .rst(rst), .clr(accept), .en(mac_en), .last(last),
        .smp(tap_smp), .coef(tap_coef), .ovf(ovf), .latch_q(acc_latch)
    );

    always_comb begin
        if (bypass) begin
            res_valid = smp_valid;
            res_data  = smp_data;
        end else begin
            res_valid = hold;
            res_data  = acc_latch[AW-1 -: DW];
        end
    end

    always_comb begin
        unique case (dbg_sel)
            2'd0: dbg_data = acc_latch[DBG_W-1:0];
            2'd1: dbg_data = DBG_W'(tap_coef);
            2'd2: dbg_data = tap_smp[DW-1 -: DBG_W];
            2'd3: dbg_data = DBG_W'({ovf, st});
            default: dbg_data = '0;
        endcase
    end
endmodule

// File: rtl/fir_serial_mac_chk.sv
module fir_serial_mac_chk #(
    parameter int TAPS      = 21,
    parameter int DW        = 10,
    parameter int AW        = 16,
    parameter int READY_LEN = 5,
    parameter int TW        = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bypass,
    input logic          smp_valid,
    input logic [DW-1:0] smp_data,
    input logic          res_valid,
    input logic [DW-1:0] res_data,
    input logic [4:0]    st,
    input logic [TW-1:0] tap,
    input logic [DW-1:0] head,
    input logic [AW-1:0] latch_q
);
    import fir_pkg::*;

    int unsigned hold_n;

    always_ff @(posedge clk) begin
        if (rst)                 hold_n <= 0;
        else if (st == ST_HOLD)  hold_n <= hold_n + 1;
        else                     hold_n <= 0;
    end

    p_state_code_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);

    p_tap_range_r4: assert property (@(posedge clk) disable iff (rst)
        tap < TW'(TAPS));

    p_run_end_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && tap == TW'(TAPS - 1)) |=> (st == ST_HOLD));

    p_hold_len_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (hold_n < READY_LEN));

    p_hold_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && hold_n == READY_LEN - 1) |=> (st == ST_IDLE));

    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(head));

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st != ST_RUN) |=> $stable(latch_q));

    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (res_valid == smp_valid && res_data == smp_data));

    p_no_accept_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (bypass && st == ST_IDLE) |=> (st == ST_IDLE));
endmodule

bind fir_serial_mac fir_serial_mac_chk #(
    .TAPS(TAPS), .DW(DW), .AW(AW), .READY_LEN(READY_LEN), .TW(TW)
) u_chk (
    .clk(clk), .rst(rst), .bypass(bypass), .smp_valid(smp_valid),
    .smp_data(smp_data), .res_valid(res_valid), .res_data(res_data),
    .st(st), .tap(tap), .head(fifo_head), .latch_q(acc_latch)
);

// File: tb/tb_fir_serial_mac.sv
module tb_fir_serial_mac;
    localparam int TAPS = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_data = '0;
    logic       bypass = 1'b0;
    logic [1:0] dbg_sel = 2'd3;
    logic       res_valid;
    logic [9:0] res_data;
    logic [5:0] dbg_data;

    int checks = 0;
    int failures = 0;
    logic signed [9:0] hist [TAPS];

    always #2 clk = ~clk;

    fir_serial_mac dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .bypass(bypass), .dbg_sel(dbg_sel), .res_valid(res_valid),
        .res_data(res_data), .dbg_data(dbg_data)
    );

    function automatic logic signed [5:0] cref(input int k);
        return 6'(31 - 3 * k);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One full pass: accept sample, walk 21 taps, then the 5-cycle hold.
    task automatic run_pass(input logic signed [9:0] s, input logic [1:0] sel,
                            input bit inj_run, input bit inj_hold);
        logic signed [15:0] part, prd, sm;
        logic ov;
        dbg_sel = sel;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = s;
        for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        @(negedge clk);
        smp_valid = 1'b0;
        part = '0;
        for (int k = 0; k < TAPS; k++) begin
            smp_valid = 1'b0;
            prd = hist[k] * cref(k);
            sm  = part + prd;
            ov  = (part[15] & prd[15] & ~sm[15]) | (~part[15] & ~prd[15] & sm[15]);
            check(res_valid == 1'b0, "R4", "valid low in RUN", res_valid, 0);
            if (sel == 2'd1) check(dbg_data == 6'(cref(k)), "R9 R3", "coef view", dbg_data, 6'(cref(k)));
            if (sel == 2'd2) check(dbg_data == hist[k][9:4], "R10", "sample view", dbg_data, hist[k][9:4]);
            if (sel == 2'd3) check(dbg_data == {ov, 5'b00010}, "R11", "ovf/state view", dbg_data, {ov, 5'b00010});
            if (inj_run && k == 5) begin
                smp_valid = 1'b1;
                smp_data  = 10'h1A5;   // must be ignored (R6)
            end
            part = sm;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        for (int j = 0; j < 5; j++) begin
            smp_valid = 1'b0;
            check(res_valid == 1'b1, "R4", "valid high in hold", res_valid, 1);
            check(res_data == part[15:6], "R2", "result", res_data, part[15:6]);
            if (sel == 2'd0) check(dbg_data == part[5:0], "R8", "low bits view", dbg_data, part[5:0]);
            if (sel == 2'd3) check(dbg_data == 6'b000100, "R11", "hold state", dbg_data, 6'b000100);
            if (inj_hold && j == 2) begin
                smp_valid = 1'b1;
                smp_data  = 10'h0F3;   // must be ignored (R6)
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check(res_valid == 1'b0, "R4", "valid falls after 5", res_valid, 0);
        check(res_data == part[15:6], "R5", "result held", res_data, part[15:6]);
        if (sel == 2'd3) check(dbg_data == 6'b000001, "R11", "back to idle", dbg_data, 6'b000001);
    endtask

    task automatic t_reset;
        for (int i = 0; i < TAPS; i++) hist[i] = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        dbg_sel = 2'd3;
        check(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
        check(res_data == 10'd0, "R1", "data in reset", res_data, 0);
        check(dbg_data == 6'b000001, "R1", "state in reset", dbg_data, 6'b000001);
        rst = 1'b0;
        @(negedge clk);
        check(dbg_data == 6'b000001, "R1", "idle after reset", dbg_data, 6'b000001);
        dbg_sel = 2'd0;
        #0;
        check(dbg_data == 6'd0, "R1 R8", "latch after reset", dbg_data, 0);
    endtask

    task automatic t_impulse;
        run_pass(10'sd100, 2'd1, 1'b0, 1'b0);
        for (int n = 0; n < 3; n++) run_pass(10'sd0, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_fullscale;
        for (int n = 0; n < TAPS; n++) run_pass(10'sd511, 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_ignore;
        run_pass(-10'sd512, 2'd0, 1'b1, 1'b1);
        run_pass(-10'sd300, 2'd2, 1'b1, 1'b0);
        run_pass(10'sd257, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_bypass;
        @(negedge clk);
        bypass = 1'b1;
        dbg_sel = 2'd3;
        for (int n = 0; n < 4; n++) begin
            smp_valid = n[0] ? 1'b0 : 1'b1;
            smp_data  = n[0] ? 10'h2AA : 10'h155;
            #1;
            check(res_valid == smp_valid, "R7", "bypass valid", res_valid, smp_valid);
            check(res_data == smp_data, "R7", "bypass data", res_data, smp_data);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        bypass = 1'b0;
        #1;
        check(dbg_data == 6'b000001, "R7", "no accept in bypass", dbg_data, 6'b000001);
        run_pass(10'sd77, 2'd0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset;
        t_impulse;
        t_fullscale;
        t_ignore;
        t_bypass;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule